// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block sits beside a NAND flash data path and works out an error correction code as bytes cross the bus. It never sits in the data path. It watches the 8-bit data bus, the active-low chip enable, and the active-low write and read strobes. It folds each transferred byte into a running parity set. The block size is programmable. When the selected number of bytes has gone by, the code is frozen in an output register and a ready flag rises. Later strobes leave the code alone until software clears it or drops the enable.

The code is built from pairs of parity bits. Three column pairs split the eight bit positions of each byte into halves. One row pair per byte-index bit splits the block's byte positions into halves. This layout lets a one-bit flip be located and a two-bit flip be flagged. A code stored alongside the page can be presented on a compare input. The block then gives the XOR of the two codes as a syndrome, plus three classification flags. Locating and repairing the bad bit is left to the consumer.

Top module: `nand_ecc_gen`

## Requirements
- R1: `size_sel` values 0, 1, 2, 3, 4 and 5 select blocks of 256, 512, 1024, 2048, 4096 and 8192 bytes, and values 6 and 7 act as 5.
- R2: Code bits 0..5 are the parity, over all bytes of the block, of data bits {0,2,4,6}, {1,3,5,7}, {0,1,4,5}, {2,3,6,7}, {0,1,2,3} and {4,5,6,7}. For each byte-index bit k below log2(block size), bit 6+2k is the parity of all bytes whose index has bit k clear, and bit 7+2k is the parity of those with bit k set. All higher code bits are zero.
- R3: `ready` stays low until the last byte of the block has been counted. It is high, with `code` valid, on the clock after the strobe edge of that byte.
- R4: A byte is counted, with `data` sampled, on the first clock at which the combined strobe (`we_n` AND `re_n`) is seen high after being low, while `ce_n` is low and `en` is high. Read and write transfers count alike.
- R5: A `clr` pulse, or `en` held low, returns `ready`, `code`, the byte count and the running parity to zero.
- R6: While `ready` is high, further strobes change neither `code` nor `ready`.
- R7: `syndrome` equals `cmp_code` XOR `code`.
- R8: `err_none` is high when the syndrome is zero. `err_single` is high when exactly log2(block size)+3 syndrome bits are set. `err_multi` is high otherwise. Exactly one of the three is high.
- R9: Strobe edges seen while `ce_n` is high are not counted and do not alter the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Bank enable; low clears the accumulation |
| clr | input | 1 | Synchronous clear pulse |
| size_sel | input | 3 | Block size select |
| ce_n | input | 1 | NAND chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| data | input | 8 | NAND data bus |
| cmp_code | input | 32 | Stored code to compare against |
| code | output | 32 | Latched code |
| ready | output | 1 | Code latched and valid |
| syndrome | output | 32 | cmp_code XOR code |
| err_none | output | 1 | Codes agree |
| err_single | output | 1 | Correctable single-bit error |
| err_multi | output | 1 | Uncorrectable error |

## Verification
The accumulation is fed with all-zero, all-one, incrementing and scrambled byte streams. All-zero shows that no parity term fires on its own. All-one shows up a wrong mask on a column term. Incrementing and scrambled streams set every index bit, so a swapped row pair or a mis-sized block shows up. Page sizes of 256, 512, 1024 and 8192 bytes are used, the last reaching the top row pair. Syndrome classes are driven by comparing against codes of the same stream with one or two bits flipped, at different byte and bit positions.

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int MIN_LOG = 8,
  parameter int MAX_LOG = 13,
  localparam int CW = 2 * MAX_LOG + 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [2:0]    size_sel,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          re_n,
  input  logic [7:0]    data,
  input  logic [CW-1:0] cmp_code,
  output logic [CW-1:0] code,
  output logic          ready,
  output logic [CW-1:0] syndrome,
  output logic          err_none,
  output logic          err_single,
  output logic          err_multi
);
  localparam int LW = $clog2(MAX_LOG + 1);
  localparam int OW = $clog2(CW + 1);

  logic [LW-1:0]      lg;
  logic [MAX_LOG-1:0] cnt, last;
  logic [CW-1:0]      acc, acc_nxt, mask;
  logic [OW-1:0]      ones;
  logic               strb, strb_q, hit, bp;

  always_comb begin
    if (int'(size_sel) + MIN_LOG > MAX_LOG) lg = LW'(MAX_LOG);
    else                                     lg = LW'(int'(size_sel) + MIN_LOG);
  end

  assign last = MAX_LOG'((32'd1 << lg) - 32'd1);
  assign strb = we_n & re_n;
  assign hit  = en & ~ce_n & ~strb_q & strb & ~ready;
  assign bp   = ^data;

  always_comb begin
    for (int i = 0; i < CW; i++) mask[i] = (i < 6 + 2 * int'(lg));
  end

  always_comb begin
    acc_nxt    = acc;
    acc_nxt[0] = acc[0] ^ (^(data & 8'h55));
    acc_nxt[1] = acc[1] ^ (^(data & 8'hAA));
    acc_nxt[2] = acc[2] ^ (^(data & 8'h33));
    acc_nxt[3] = acc[3] ^ (^(data & 8'hCC));
    acc_nxt[4] = acc[4] ^ (^(data & 8'h0F));
    acc_nxt[5] = acc[5] ^ (^(data & 8'hF0));
    for (int k = 0; k < MAX_LOG; k++) begin
      if (cnt[k]) acc_nxt[7 + 2*k] = acc[7 + 2*k] ^ bp;
      else        acc_nxt[6 + 2*k] = acc[6 + 2*k] ^ bp;
    end
    acc_nxt = acc_nxt & mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      acc    <= '0;
      cnt    <= '0;
      code   <= '0;
      ready  <= 1'b0;
    end else begin
      strb_q <= strb;
      if (clr || !en) begin
        acc   <= '0;
        cnt   <= '0;
        code  <= '0;
        ready <= 1'b0;
      end else if (hit) begin
        if (cnt == last) begin
          code  <= acc_nxt;
          ready <= 1'b1;
          acc   <= '0;
          cnt   <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign syndrome = cmp_code ^ code;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CW; i++) ones = ones + OW'(syndrome[i]);
  end

  assign err_none   = (syndrome == '0);
  assign err_single = (int'(ones) == int'(lg) + 3);
  assign err_multi  = !err_none && !err_single;

  assert_hold_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(code));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (!ready && code == '0 && cnt == '0));

  assert_block_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(cnt) == $past(last)));

  assert_ce_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_n) && $past(en) && !$past(clr)) |-> $stable(cnt));

  assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_none, err_single, err_multi}) == 1);
endmodule

// File: tb/test_nand_ecc_gen.sv
module test_nand_ecc_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0;
  logic [2:0] size_sel = 3'd0;
  logic ce_n = 1'b1, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic [CW-1:0] cmp_code = '0, code, syndrome;
  logic ready, err_none, err_single, err_multi;
  int checks = 0, errors = 0, cycles = 0;

  nand_ecc_gen i_nand_ecc_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .size_sel(size_sel),
    .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .data(data), .cmp_code(cmp_code),
    .code(code), .ready(ready), .syndrome(syndrome),
    .err_none(err_none), .err_single(err_single), .err_multi(err_multi));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [7:0] pat_byte(int pat, int i);
    case (pat)
      0: return 8'h00;
      1: return 8'hFF;
      2: return i[7:0];
      default: return 8'((i * 37 + 11) ^ (i >> 8));
    endcase
  endfunction

  function automatic logic [CW-1:0] model(int lgs, int pat, int n,
                                           int fb1, int fi1, int fb2, int fi2);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = pat_byte(pat, i);
      if (i == fb1) d[fi1] = ~d[fi1];
      if (i == fb2) d[fi2] = ~d[fi2];
      for (int j = 0; j < 8; j++)
        if (d[j]) begin
          c[j % 2 == 1 ? 1 : 0] ^= 1'b1;
          c[(j / 2) % 2 == 1 ? 3 : 2] ^= 1'b1;
          c[j >= 4 ? 5 : 4] ^= 1'b1;
        end
      for (int k = 0; k < lgs; k++)
        c[6 + 2*k + ((i >> k) & 1)] ^= ^d;
    end
    return c;
  endfunction

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] d, bit use_re, bit ce);
    @(negedge clk);
    data = d; ce_n = ce;
    if (use_re) re_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; re_n = 1'b1;
  endtask

  task automatic feed(int pat, int from, int n, bit use_re);
    for (int i = from; i < from + n; i++) send_byte(pat_byte(pat, i), use_re, 1'b0);
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic do_clear;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset;
    check("R5 reset ready", CW'(ready), 0);
    check("R5 reset code", code, '0);
  endtask

  task automatic t_block(int sel, int pat, bit use_re, string req);
    int n = 1 << (8 + sel);
    do_clear();
    size_sel = 3'(sel);
    feed(pat, 0, n - 1, use_re);
    check({req, " R3 ready low before last"}, CW'(ready), 0);
    feed(pat, n - 1, 1, use_re);
    check({req, " R3 ready after last"}, CW'(ready), 1);
    check({req, " R2 code"}, code, model(8 + sel, pat, n, -1, 0, -1, 0));
  endtask

  task automatic t_hold;
    logic [CW-1:0] held;
    t_block(0, 2, 1'b0, "R1");
    held = code;
    feed(1, 0, 5, 1'b0);
    check("R6 code held", code, held);
    check("R6 ready held", CW'(ready), 1);
  endtask

  task automatic t_clear;
    t_block(0, 3, 1'b0, "R1");
    do_clear();
    check("R5 clr ready", CW'(ready), 0);
    check("R5 clr code", code, '0);
    feed(1, 0, 10, 1'b0);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    feed(2, 0, 256, 1'b0);
    check("R5 en low restarts count", code, model(8, 2, 256, -1, 0, -1, 0));
  endtask

  task automatic t_ce;
    do_clear();
    size_sel = 3'd0;
    for (int i = 0; i < 7; i++) send_byte(8'hA5, 1'b0, 1'b1);
    feed(3, 0, 256, 1'b0);
    check("R9 ce_n high ignored", code, model(8, 3, 256, -1, 0, -1, 0));
  endtask

  task automatic t_syndrome;
    logic [CW-1:0] good, one, two;
    t_block(0, 3, 1'b0, "R1");
    good = model(8, 3, 256, -1, 0, -1, 0);
    one  = model(8, 3, 256, 77, 5, -1, 0);
    two  = model(8, 3, 256, 12, 0, 200, 6);
    @(negedge clk); cmp_code = good;
    @(negedge clk);
    check("R8 none", {err_none, err_single, err_multi}, 3'b100);
    cmp_code = one;
    @(negedge clk);
    check("R7 syndrome", syndrome, one ^ good);
    check("R8 single", {err_none, err_single, err_multi}, 3'b010);
    cmp_code = two;
    @(negedge clk);
    check("R8 double", {err_none, err_single, err_multi}, 3'b001);
    cmp_code = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; en = 1'b1;
    t_block(0, 2, 1'b0, "R1 256");
    t_block(1, 3, 1'b0, "R1 512");
    t_block(2, 1, 1'b1, "R4 read strobe 1024");
    t_block(0, 0, 1'b0, "R2 zeros");
    t_block(5, 2, 1'b0, "R1 8192");
    t_hold();
    t_clear();
    t_ce();
    t_syndrome();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule